// File: doc/BRIEF.md
# Reloadable Down-Counter with One-Shot Mode

This block is a small programmable timer core. An up-to-date reload value is held in a register, and a live counter counts down from that value by one on every count-enable strobe while the block is running. A count-enable strobe that arrives while the counter already holds zero is an underflow. On an underflow the counter takes the reload value again and a one-cycle underflow pulse comes out. In continuous mode the block keeps running after that. In one-shot mode it drops its own run bit and waits for software.

Software drives a single write port. A select bit picks either the reload register or the control word. The control word carries the run bit, the mode bit and a preset strobe, and the preset strobe copies the reload value into the counter at once. The block returns the reload value, the control word (with the strobe position always zero) and the live count, so software can read back its state.

Top module: `reload_downcounter`

## Requirements
- R1: After reset the count is FFh, the reload value is FFh, the run bit and the continuous bit are 0, and the underflow output is low.
- R2: A write with `wr_sel`=0 stores `wr_data` as the reload value. A write with `wr_sel`=1 sets the run bit from bit 0 and the continuous bit from bit 1. Bit 2 of that write is the preset strobe. `ctrl_rd` returns {0, continuous, run}, so the strobe position always reads 0.
- R3: When the run bit is 1, `cnt_en` is high, the count is not 00h and no preset is written, the count drops by exactly one at the next clock.
- R4: When the run bit is 0 or `cnt_en` is low, and no preset is written, the count does not change.
- R5: A count-enable event taken while the count is 00h and the run bit is 1, with no preset written, is an underflow. In the next cycle the count equals the reload value held before the edge, and `underflow` is high for that one cycle only.
- R6: In continuous mode (continuous bit = 1) an underflow leaves the run bit at 1, and counting goes on from the reload value.
- R7: In one-shot mode (continuous bit = 0) an underflow reloads the counter and clears the run bit to 0, so later count-enable strobes do not move the count.
- R8: A control write with bit 2 set loads the reload value into the counter at the next clock. This happens whether the run bit is 0 or 1.
- R9: A preset written in the same cycle as a decrement or an underflow event takes priority. The count becomes the reload value, no underflow pulse is produced, and the run bit is not cleared by that event.
- R10: A control write that coincides with a one-shot underflow sets the run bit to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count-enable strobe from the input stage |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = reload register, 1 = control word |
| wr_data | input | W | Write data; control bits: 0 run, 1 continuous, 2 preset |
| count | output | W | Live counter value |
| underflow | output | 1 | One-cycle pulse after an underflow |
| reload_rd | output | W | Reload register readback |
| ctrl_rd | output | 3 | {0, continuous, run} |

## Verification
The hardest situations to reach are the ones where a preset strobe or a control write lands in exactly the cycle where the counter sits at zero and a count-enable arrives. Directed sequences set these up by presetting a reload value of 0 or 1 and timing the collision. Random stimulus then writes mostly reload values from 0 to 3, so that underflows happen every few strobes and collide often with writes in both modes.

// File: rtl/reload_downcounter.sv
module reload_downcounter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic         underflow,
  output logic [W-1:0] reload_rd,
  output logic [2:0]   ctrl_rd
);
  localparam logic [W-1:0] INIT = {W{1'b1}};

  logic [W-1:0] reload_q, count_q;
  logic         run_q, cont_q, uflow_q;

  wire ctrl_wr = wr_en & wr_sel;
  wire rld_wr  = wr_en & ~wr_sel;
  wire preset  = ctrl_wr & wr_data[2];
  wire tick    = run_q & cnt_en;
  wire wrap    = tick & (count_q == '0) & ~preset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= INIT;
      count_q  <= INIT;
      run_q    <= 1'b0;
      cont_q   <= 1'b0;
      uflow_q  <= 1'b0;
    end else begin
      if (rld_wr) reload_q <= wr_data;
      if (ctrl_wr) begin
        run_q  <= wr_data[0];
        cont_q <= wr_data[1];
      end else if (wrap && !cont_q) begin
        run_q <= 1'b0;
      end
      if (preset || wrap) count_q <= reload_q;
      else if (tick)      count_q <= count_q - 1'b1;
      uflow_q <= wrap;
    end
  end

  assign count     = count_q;
  assign underflow = uflow_q;
  assign reload_rd = reload_q;
  assign ctrl_rd   = {1'b0, cont_q, run_q};
endmodule

// File: rtl/reload_downcounter_chk.sv
module reload_downcounter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         wr_en,
  input logic         wr_sel,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] count,
  input logic         underflow,
  input logic [W-1:0] reload_rd,
  input logic [2:0]   ctrl_rd
);
  logic cw, pw, go, zero;
  assign cw   = wr_en && wr_sel;
  assign pw   = cw && wr_data[2];
  assign go   = ctrl_rd[0] && cnt_en;
  assign zero = (count == '0);

  p_strobe_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[2] == 1'b0);
  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go && !zero && !pw |=> count == $past(count) - W'(1));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !go && !pw |=> $stable(count));
  p_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go && zero && !pw |=> underflow && count == $past(reload_rd));
  p_uflow_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> $past(go && zero && !pw));
  p_continuous_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go && zero && !pw && ctrl_rd[1] && !cw |=> ctrl_rd[0]);
  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go && zero && !pw && !ctrl_rd[1] && !cw |=> !ctrl_rd[0]);
  p_preset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pw |=> count == $past(reload_rd));
  p_preset_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pw |=> !underflow);
  p_ctrl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> ctrl_rd[0] == $past(wr_data[0]) && ctrl_rd[1] == $past(wr_data[1]));
endmodule

bind reload_downcounter reload_downcounter_chk #(.W(W)) u_chk (.*);

// File: tb/sim_reload_downcounter.sv
`timescale 1ns/1ps
module sim_reload_downcounter;
  logic       clk = 0, rst_n = 0, cnt_en = 0, wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] count, reload_rd;
  logic       underflow;
  logic [2:0] ctrl_rd;

  int errors = 0, checks = 0;
  logic [7:0] m_cnt, m_rld;
  logic       m_run, m_cont, m_uf;

  always #5 clk = ~clk;

  reload_downcounter #(.W(8)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R3/R4/R5/R8 count", count, m_cnt);
    chk("R5/R9 underflow", underflow, m_uf);
    chk("R2/R6/R7/R10 ctrl_rd", ctrl_rd, {1'b0, m_cont, m_run});
    chk("R2 reload_rd", reload_rd, m_rld);
  endtask

  task automatic cyc(input logic e, input logic we, input logic sel, input logic [7:0] d);
    logic pre, tk, wr;
    cnt_en = e; wr_en = we; wr_sel = sel; wr_data = d;
    pre = we && sel && d[2];
    tk  = m_run && e;
    wr  = tk && m_cnt == 8'h00 && !pre;
    @(negedge clk);
    if (pre || wr) m_cnt = m_rld;
    else if (tk)   m_cnt = m_cnt - 8'd1;
    if (we && sel) begin m_run = d[0]; m_cont = d[1]; end
    else if (wr && !m_cont) m_run = 1'b0;
    if (we && !sel) m_rld = d;
    m_uf = wr;
    compare();
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_cnt = 8'hFF; m_rld = 8'hFF; m_run = 0; m_cont = 0; m_uf = 0;
    compare(); // R1
    cyc(1, 0, 0, 0);             // R4: not running
    cyc(0, 1, 0, 8'h02);         // R2 reload=2
    cyc(0, 1, 1, 8'h04);         // R8 preset while stopped
    cyc(1, 1, 1, 8'h01);         // run, one-shot
    repeat (4) cyc(1, 0, 0, 0);  // R3, R5, R7
    repeat (3) cyc(1, 0, 0, 0);  // R7 stopped stays
    cyc(0, 1, 1, 8'h07);         // continuous + preset + run
    repeat (8) cyc(1, 0, 0, 0);  // R6
    cyc(0, 1, 0, 8'h00);         // reload 0
    cyc(0, 1, 1, 8'h05);         // preset, one-shot run
    cyc(1, 1, 1, 8'h05);         // R9 preset vs underflow
    cyc(1, 1, 1, 8'h01);         // R10 write during one-shot underflow
    cyc(1, 0, 0, 0);
    cyc(0, 1, 1, 8'h03);         // continuous reload 0: back-to-back underflows
    repeat (3) cyc(1, 0, 0, 0);
    repeat (4000) begin
      logic e, we, sel;
      logic [7:0] d;
      e   = ($urandom % 2) == 0;
      we  = ($urandom % 8) == 0;
      sel = $urandom % 2;
      d   = $urandom;
      if (!sel && ($urandom % 4) != 0) d = d % 4;
      if (sel && ($urandom % 3) != 0) d[2] = 1'b0;
      cyc(e, we, sel, d);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule